// File: doc/BRIEF.md
# Banked 16-bit ALU with Saturating and Sticky-Overflow Modes

This block is the arithmetic/logic unit of a fixed-point signal processor core. It holds its own operand registers: two X registers, two Y registers, a result register and a feedback register. There are two complete copies of this set, and a bank-select mode bit chooses which copy is live. Each cycle an operation can read one X operand and one Y operand (the Y operand may be the feedback register). It computes an add, subtract, negate or bitwise function and writes the outcome into either the result or the feedback register of the live bank.

Each operation also updates an 8-bit status word. The word holds zero, negative, overflow and carry flags, the sign of the X operand and a held quotient bit. Two mode bits change how overflow is treated. With the sticky bit set, the overflow flag stays set until software writes the status word. With the saturate bit set, an overflowing result is clamped to the largest positive or most negative 16-bit value instead of wrapping around. A separate register write port loads any register of the live bank, and a status write port loads the flags directly.

Top module: `sat_alu`

## Requirements
- R1: After an asynchronous active-low reset, every register in both banks and every status bit is zero, so `ar`, `af` and `astat` read 0.
- R2: When `wr_en` is high, `wr_data` is loaded into the live-bank register picked by `wr_sel`. The encoding is 0 X0, 1 X1, 2 Y0, 3 Y1, 4 result, 5 feedback; codes 6 and 7 write nothing. The new `ar`/`af` value appears after the clock edge.
- R3: When `op_valid` is high, `op_code` picks the function: 0 X+Y, 1 X+Y+carry, 2 X−Y, 3 Y−X, 4 AND, 5 OR, 6 XOR, 7 NOT X, 8 pass X, 9 negate X; codes 10 to 15 act as pass X. `x_sel` 0/1 picks X0/X1. `y_sel` 0 picks Y0, 1 picks Y1, and 2 or 3 picks the feedback register. The result is registered into the result register (`res_dst`=0) or the feedback register (`res_dst`=1) at the edge, and wraps modulo 2^16 when saturation is off.
- R4: On each operation, status bit 0 is set when the stored result is zero and bit 1 copies the stored result's bit 15.
- R5: Status bit 3 is the carry out of the 16-bit addition. Subtraction is formed as A + NOT B + 1, so 1 means no borrow. Negate is 0 + NOT X + 1. Code 1 adds the current bit 3 as carry-in. Codes 4 to 8 clear bit 3.
- R6: With the sticky mode off, status bit 2 is set exactly when the operation overflowed as a signed 16-bit value. Codes 4 to 8 never overflow.
- R7: With the sticky mode on, status bit 2 is ORed with the new overflow, so once set it stays set through later operations until a status write.
- R8: With the saturate mode on, a result that overflows positively is stored as 0x7FFF and one that overflows negatively as 0x8000. Status bit 2 still reports the overflow.
- R9: On each operation, status bit 4 copies bit 15 of the selected X operand.
- R10: `stat_wr` loads `stat_wdata` into status bits 5..0. Bit 5 (quotient) changes only this way. A status write takes priority over the flag update of an operation in the same cycle, and bits 7..6 read 0.
- R11: `mode_bank` is registered. Operations, register writes and the `ar`/`af` outputs use the bank chosen in the previous cycle, and the inactive bank keeps its contents.
- R12: When an operation and a register write target the same register in one cycle, the operation result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register picked for the write |
| wr_data | input | 16 | Register write data |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| x_sel | input | 1 | X operand select |
| y_sel | input | 2 | Y operand select |
| res_dst | input | 1 | Destination: 0 result, 1 feedback |
| mode_bank | input | 1 | Register bank select |
| mode_sticky | input | 1 | Sticky overflow mode |
| mode_sat | input | 1 | Saturating result mode |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 6 | Status write data for bits 5..0 |
| ar | output | 16 | Result register of the live bank |
| af | output | 16 | Feedback register of the live bank |
| astat | output | 8 | Status word |

## Verification
All ten operations run over every pair drawn from eight operand values. The set includes zero, one, both 16-bit extremes and their neighbours, so each pair falls on one side of the carry and signed-overflow boundaries. This separates a wrong carry definition from a wrong overflow rule. The sweep is repeated under all four combinations of the saturate and sticky modes. Saturation tells positive from negative clamping, and the sticky runs show whether a later clean operation wrongly clears the overflow flag. Directed sequences then cover the second operand registers, the feedback path, status write priority, the one-cycle delay of a bank switch and write collisions.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  localparam int NREGS = 6;
  localparam int NBANK = 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_RSUB = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOTX = 4'd7,
    OP_PASS = 4'd8,
    OP_NEGX = 4'd9
  } alu_op_e;

  localparam int RI_X0 = 0;
  localparam int RI_X1 = 1;
  localparam int RI_Y0 = 2;
  localparam int RI_Y1 = 3;
  localparam int RI_AR = 4;
  localparam int RI_AF = 5;

  localparam int FL_AZ = 0;
  localparam int FL_AN = 1;
  localparam int FL_AV = 2;
  localparam int FL_AC = 3;
  localparam int FL_AS = 4;
  localparam int FL_AQ = 5;
  localparam int FL_N  = 6;
endpackage

// File: rtl/sat_alu_bank.sv
module sat_alu_bank
  import sat_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [2:0]                wr_sel,
  input  logic [DW-1:0]             wr_data,
  input  logic                      res_en,
  input  logic                      res_dst,
  input  logic [DW-1:0]             res_data,
  output logic [NREGS-1:0][DW-1:0]  regs_o
);
  int res_idx;
  assign res_idx = res_dst ? RI_AF : RI_AR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_o <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (res_en && (i == res_idx))
          regs_o[i] <= res_data;
        else if (wr_en && (wr_sel == 3'(i)))
          regs_o[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sat_alu_dp.sv
module sat_alu_dp
  import sat_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [3:0]    op,
  input  logic          c_in,
  input  logic          sat_en,
  output logic [DW-1:0] res,
  output logic          carry,
  output logic          ovf,
  output logic          sat_hit,
  output logic          is_logic
);
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MAX_NEG = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW:0] add_full(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic ci);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  endfunction

  function automatic logic signed_ovf(input logic a_msb, input logic b_msb, input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  logic [DW-1:0] opa, opb, lres;
  logic          ci, arith;
  logic [DW:0]   sum;

  always_comb begin
    opa   = '0;
    opb   = '0;
    ci    = 1'b0;
    arith = 1'b1;
    lres  = x;
    case (op)
      OP_ADD:  begin opa = x;  opb = y;  end
      OP_ADC:  begin opa = x;  opb = y;  ci = c_in; end
      OP_SUB:  begin opa = x;  opb = ~y; ci = 1'b1; end
      OP_RSUB: begin opa = y;  opb = ~x; ci = 1'b1; end
      OP_NEGX: begin opa = '0; opb = ~x; ci = 1'b1; end
      OP_AND:  begin arith = 1'b0; lres = x & y; end
      OP_OR:   begin arith = 1'b0; lres = x | y; end
      OP_XOR:  begin arith = 1'b0; lres = x ^ y; end
      OP_NOTX: begin arith = 1'b0; lres = ~x; end
      default: begin arith = 1'b0; lres = x; end
    endcase
  end

  assign sum      = add_full(opa, opb, ci);
  assign ovf      = arith && signed_ovf(opa[DW-1], opb[DW-1], sum[DW-1]);
  assign carry    = arith && sum[DW];
  assign sat_hit  = ovf && sat_en;
  assign is_logic = !arith;
  assign res      = sat_hit ? (opa[DW-1] ? MAX_NEG : MAX_POS)
                            : (arith ? sum[DW-1:0] : lres);
endmodule

// File: rtl/sat_alu_flags.sv
module sat_alu_flags
  import sat_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic            stat_wr,
  input  logic [FL_N-1:0] stat_wdata,
  input  logic            sticky,
  input  logic [DW-1:0]   res,
  input  logic            carry,
  input  logic            ovf,
  input  logic            x_msb,
  output logic [7:0]      astat
);
  logic [FL_N-1:0] fl_q, fl_d;

  always_comb begin
    fl_d        = fl_q;
    fl_d[FL_AZ] = (res == '0);
    fl_d[FL_AN] = res[DW-1];
    fl_d[FL_AV] = ovf | (sticky & fl_q[FL_AV]);
    fl_d[FL_AC] = carry;
    fl_d[FL_AS] = x_msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fl_q <= '0;
    else if (stat_wr) fl_q <= stat_wdata;
    else if (upd)     fl_q <= fl_d;
  end

  assign astat = {{(8-FL_N){1'b0}}, fl_q};
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic          x_sel,
  input  logic [1:0]    y_sel,
  input  logic          res_dst,
  input  logic          mode_bank,
  input  logic          mode_sticky,
  input  logic          mode_sat,
  input  logic          stat_wr,
  input  logic [5:0]    stat_wdata,
  output logic [DW-1:0] ar,
  output logic [DW-1:0] af,
  output logic [7:0]    astat
);
  logic                     bank_q;
  logic [NREGS-1:0][DW-1:0] bank_regs [NBANK];
  logic [NREGS-1:0][DW-1:0] live;
  logic [DW-1:0]            xval, yval, res_val;
  logic                     carry_evt, ovf_evt, sat_evt, logic_evt, x_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= 1'b0;
    else        bank_q <= mode_bank;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sat_alu_bank #(.DW(DW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (bank_q == 1'(b))),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .res_en   (op_valid && (bank_q == 1'(b))),
      .res_dst  (res_dst),
      .res_data (res_val),
      .regs_o   (bank_regs[b])
    );
  end

  assign live  = bank_regs[bank_q];
  assign xval  = x_sel ? live[RI_X1] : live[RI_X0];
  assign yval  = (y_sel == 2'd0) ? live[RI_Y0] :
                 (y_sel == 2'd1) ? live[RI_Y1] : live[RI_AF];
  assign x_msb = xval[DW-1];

  sat_alu_dp #(.DW(DW)) u_dp (
    .x        (xval),
    .y        (yval),
    .op       (op_code),
    .c_in     (astat[FL_AC]),
    .sat_en   (mode_sat),
    .res      (res_val),
    .carry    (carry_evt),
    .ovf      (ovf_evt),
    .sat_hit  (sat_evt),
    .is_logic (logic_evt)
  );

  sat_alu_flags #(.DW(DW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (op_valid),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .sticky     (mode_sticky),
    .res        (res_val),
    .carry      (carry_evt),
    .ovf        (ovf_evt),
    .x_msb      (x_msb),
    .astat      (astat)
  );

  assign ar = live[RI_AR];
  assign af = live[RI_AF];
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          stat_wr,
  input logic [5:0]    stat_wdata,
  input logic          mode_sticky,
  input logic          mode_bank,
  input logic          bank_q,
  input logic          res_dst,
  input logic [DW-1:0] ar,
  input logic [DW-1:0] af,
  input logic [7:0]    astat,
  input logic          sat_evt,
  input logic          logic_evt,
  input logic          x_msb
);
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MAX_NEG = {1'b1, {(DW-1){1'b0}}};

  a_r8_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_evt && (mode_bank == bank_q)) |=>
      ((($past(res_dst) ? af : ar) == MAX_POS) || (($past(res_dst) ? af : ar) == MAX_NEG)));

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sticky && astat[2] && !stat_wr) |=> astat[2]);

  a_r5_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && logic_evt && !stat_wr) |=> !astat[3]);

  a_r6_logic_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && logic_evt && !stat_wr && !mode_sticky) |=> !astat[2]);

  a_r9_x_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !stat_wr) |=> (astat[4] == $past(x_msb)));

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !stat_wr && !res_dst && (mode_bank == bank_q)) |=> (astat[0] == (ar == '0)));

  a_r10_status_load: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (astat[5:0] == $past(stat_wdata)));
endmodule

bind sat_alu sat_alu_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .stat_wr     (stat_wr),
  .stat_wdata  (stat_wdata),
  .mode_sticky (mode_sticky),
  .mode_bank   (mode_bank),
  .bank_q      (bank_q),
  .res_dst     (res_dst),
  .ar          (ar),
  .af          (af),
  .astat       (astat),
  .sat_evt     (sat_evt),
  .logic_evt   (logic_evt),
  .x_msb       (x_msb)
);

// File: tb/sat_alu_bench.sv
module sat_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic        x_sel = 1'b0;
  logic [1:0]  y_sel = '0;
  logic        res_dst = 1'b0;
  logic        mode_bank = 1'b0;
  logic        mode_sticky = 1'b0;
  logic        mode_sat = 1'b0;
  logic        stat_wr = 1'b0;
  logic [5:0]  stat_wdata = '0;
  logic [15:0] ar, af;
  logic [7:0]  astat;

  sat_alu u_sat_alu (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .op_valid(op_valid), .op_code(op_code), .x_sel(x_sel), .y_sel(y_sel),
    .res_dst(res_dst), .mode_bank(mode_bank), .mode_sticky(mode_sticky),
    .mode_sat(mode_sat), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .ar(ar), .af(af), .astat(astat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  logic [15:0] mreg [2][6];
  logic        mbank = 1'b0;
  logic [5:0]  mfl = '0;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    mbank = mode_bank;
  endtask

  task automatic do_write(input int sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
    tick();
    if (sel < 6) mreg[mbank ^ (mode_bank ^ mbank)][sel] = d;
    wr_en = 1'b0;
  endtask

  task automatic do_op(input int op, input int xs, input int ys, input int dst, input string rtag);
    logic [15:0] x, y, r;
    int sx, sy, ss, us;
    logic c, v, arith;
    logic b;
    b = mbank;
    x = xs ? mreg[b][1] : mreg[b][0];
    y = (ys == 0) ? mreg[b][2] : (ys == 1) ? mreg[b][3] : mreg[b][5];
    sx = (int'(x) >= 32768) ? int'(x) - 65536 : int'(x);
    sy = (int'(y) >= 32768) ? int'(y) - 65536 : int'(y);
    arith = 1'b1; us = 0; ss = 0; r = x;
    case (op)
      0: begin us = int'(x) + int'(y); ss = sx + sy; end
      1: begin us = int'(x) + int'(y) + int'(mfl[3]); ss = sx + sy + int'(mfl[3]); end
      2: begin us = int'(x) + (65535 - int'(y)) + 1; ss = sx - sy; end
      3: begin us = int'(y) + (65535 - int'(x)) + 1; ss = sy - sx; end
      9: begin us = (65535 - int'(x)) + 1; ss = -sx; end
      4: begin arith = 1'b0; r = x & y; end
      5: begin arith = 1'b0; r = x | y; end
      6: begin arith = 1'b0; r = x ^ y; end
      7: begin arith = 1'b0; r = ~x; end
      default: begin arith = 1'b0; r = x; end
    endcase
    if (arith) begin
      c = (us >= 65536);
      v = (ss > 32767) || (ss < -32768);
      r = 16'(us % 65536);
      if (v && mode_sat) r = (ss > 0) ? 16'h7FFF : 16'h8000;
    end else begin
      c = 1'b0; v = 1'b0;
    end
    op_valid = 1'b1; op_code = 4'(op); x_sel = xs[0]; y_sel = 2'(ys); res_dst = dst[0];
    tick();
    if (wr_en && wr_sel < 3'd6) mreg[b][wr_sel] = wr_data;
    mreg[b][dst ? 5 : 4] = r;
    if (stat_wr) mfl = stat_wdata;
    else mfl = {mfl[5], x[15], c, v | (mode_sticky & mfl[2]), r[15], (r == 16'h0)};
    chk(rtag, dst ? af : ar, mreg[mbank][dst ? 5 : 4]);
    chk(rtag, dst ? ar : af, mreg[mbank][dst ? 4 : 5]);
    if (stat_wr) chk("R10 status", {8'h0, astat}, {10'h0, mfl});
    else begin
      chk("R4 zero/neg", {14'h0, astat[1:0]}, {14'h0, mfl[1:0]});
      chk("R5 carry", {15'h0, astat[3]}, {15'h0, mfl[3]});
      chk(mode_sticky ? "R7 sticky ovf" : "R6 ovf", {15'h0, astat[2]}, {15'h0, mfl[2]});
      chk("R9 x sign", {15'h0, astat[4]}, {15'h0, mfl[4]});
      chk("R10 quotient held", {8'h0, astat[7:5]}, {13'h0, 2'b00, mfl[5]});
    end
    op_valid = 1'b0;
    wr_en = 1'b0;
    stat_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : main
    logic [15:0] vals [8];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'h5555; vals[6] = 16'hC000; vals[7] = 16'h4000;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 6; i++) mreg[b][i] = '0;

    repeat (2) @(negedge clk);
    chk("R1 reset ar", ar, 16'h0);
    chk("R1 reset af", af, 16'h0);
    chk("R1 reset astat", {8'h0, astat}, 16'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", {8'h0, astat}, 16'h0);

    do_write(4, 16'hBEEF);
    chk("R2 write result reg", ar, 16'hBEEF);
    do_write(5, 16'h1357);
    chk("R2 write feedback reg", af, 16'h1357);
    do_write(6, 16'hFFFF);
    chk("R2 code 6 writes nothing ar", ar, 16'hBEEF);
    chk("R2 code 6 writes nothing af", af, 16'h1357);

    for (int m = 0; m < 4; m++) begin
      mode_sat = m[0]; mode_sticky = m[1];
      stat_wr = 1'b1; stat_wdata = 6'h00;
      tick();
      stat_wr = 1'b0; mfl = '0;
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          do_write(0, vals[i]);
          do_write(2, vals[j]);
          for (int op = 0; op < 10; op++)
            do_op(op, 0, 0, 0, mode_sat ? "R8 saturated result" : "R3 result");
        end
      end
    end
    mode_sat = 1'b0; mode_sticky = 1'b0;

    do_write(1, 16'h0F0F);
    do_write(3, 16'h00FF);
    do_op(0, 1, 1, 1, "R3 X1+Y1 into feedback");
    do_op(2, 1, 2, 0, "R3 X1 minus feedback");
    do_op(12, 1, 3, 0, "R3 code 12 passes X");

    mode_sticky = 1'b1;
    do_write(0, 16'h7FFF); do_write(2, 16'h0001);
    do_op(0, 0, 0, 0, "R7 overflow add");
    do_op(4, 0, 0, 0, "R7 logic keeps sticky");
    stat_wr = 1'b1; stat_wdata = 6'h20;
    tick();
    stat_wr = 1'b0; mfl = 6'h20;
    chk("R10 status write clears ovf, sets quotient", {8'h0, astat}, 16'h0020);
    mode_sticky = 1'b0;
    do_op(0, 0, 0, 0, "R10 quotient held across op");
    stat_wr = 1'b1; stat_wdata = 6'h15;
    do_op(2, 0, 0, 0, "R10 status write beats op");

    do_write(0, 16'h00AA);
    do_op(8, 0, 0, 0, "R11 bank0 result");
    mode_bank = 1'b1;
    do_op(8, 0, 0, 1, "R11 op in switch cycle uses old bank");
    chk("R11 new bank result reg", ar, 16'h0000);
    chk("R11 new bank feedback reg", af, 16'h0000);
    do_write(0, 16'h0011);
    do_op(8, 0, 0, 0, "R11 op in bank1");
    mode_bank = 1'b0;
    tick();
    chk("R11 bank0 result kept", ar, 16'h00AA);
    chk("R11 bank0 feedback kept", af, 16'h00AA);
    do_op(7, 0, 0, 0, "R11 bank0 X0 kept");
    chk("R11 bank0 X0 kept value", ar, 16'hFF55);

    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 16'h5A5A;
    do_op(8, 0, 0, 0, "R12 op beats write same reg");
    chk("R12 result reg", ar, 16'h00AA);
    wr_en = 1'b1; wr_sel = 3'd5; wr_data = 16'h5A5A;
    do_op(9, 0, 0, 0, "R12 write to other reg lands");
    chk("R12 feedback written", af, 16'h5A5A);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule